// File: doc/BRIEF.md
# Four-Channel Down-Counting Timer Peripheral

This peripheral holds several independent 32-bit timers that count down from a programmed start value. Software reaches every register through a plain register bus with an address, write data, a write strobe, a read strobe and read data. A single control register at the top of the map holds one enable that starts or holds every channel at once. Next to it sits a fixed identification value that can only be read.

Each channel has its own 0x20-byte window with seven registers: a local enable, the start (reload) value, the visible count, a wrap counter, an interrupt status flag, an interrupt clear and an interrupt mask. A channel counts down one step per clock while both its own enable and the global enable are set. When the count is at zero on a counting cycle, the channel reloads, adds one to its wrap counter and raises its status flag. Reading the wrap counter also copies the live count into a holding register. The count register returns that copy, so software reads the wrap counter first and the count second. With a start value of all ones the channel runs freely, and the bitwise inverse of the captured count grows as time passes. Each channel drives its own interrupt line, and one combined line ORs all of them.

Top module: `quad_down_timer`

## Requirements
- R1: After a synchronous active-high reset, every writable register, count, wrap counter, snapshot and status flag is zero, rdata is zero, and all interrupt outputs are low. The identification register at 0x10 reads 0x00020001.
- R2: Channel n (0..3) has its window at 0x20·(n+1). Within the window the offsets are: enable 0x00 (bit 0), reload 0x04, count 0x08, wrap counter 0x0C, status 0x10 (bit 0), clear 0x14, mask 0x18 (bit 0). Enable, reload and mask read back as written. Writes to the identification register have no effect. Unmapped, misaligned and clear-register reads return zero.
- R3: Bit 0 at address 0x00 is the global enable. While it is clear, no channel's count changes except by a load.
- R4: A channel counts only while both its local enable and the global enable are set. Clearing the local enable freezes the count.
- R5: Writing 1 to bit 0 of a channel's enable register while that enable is clear loads the reload value into the count. The load happens even when the global enable is clear.
- R6: A running channel with a nonzero count decrements it by one on each clock.
- R7: A running channel whose count is zero reloads, increments its 32-bit wrap counter and sets its status bit on that same edge. One period therefore lasts reload+1 cycles.
- R8: A read of the wrap counter returns its value and captures the current count into a snapshot. The count register returns the snapshot and changes only on such a read.
- R9: rdata is registered. It shows the addressed value on the clock edge that samples rd_en and holds it until the next read.
- R10: Writing 1 to bit 0 of the clear register clears the status bit, and a write with bit 0 equal to 0 leaves the status unchanged. If a wrap happens on the same edge as a clear, the set wins.
- R11: irq[n] is high exactly when status bit n and mask bit n are both 1, and irq_any is the OR of all irq lines. A mask of zero keeps irq[n] low.
- R12: With a reload of 0xFFFFFFFF, the inverse of successive captured counts rises by the number of cycles elapsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Byte address of the register access |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rdata | output | 32 | Registered read data |
| irq | output | 4 | Per-channel interrupt lines |
| irq_any | output | 1 | OR of all channel interrupt lines |

## Verification
Every register write takes effect on the edge that samples wr_en. Read data appears on the edge that samples rd_en, and a running channel's first decrement comes one edge after the edge that enabled it. The bench drives each access for exactly one edge and samples at the following falling edge. For that edge it records how many rising edges have passed since reset. From the recorded numbers of the enable edge and the wrap-counter read edge it computes the expected count and wrap total: k = read - enable, wraps = (k-1)/(R+1), count = R - (k-1) mod (R+1). Interrupt lines are checked at the falling edge right after the mask or clear write, since they follow registered state with no further delay.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

    localparam int DW = 32;
    localparam logic [DW-1:0] REVISION = 32'h0002_0001;

    // top-level page offsets
    localparam logic [4:0] TOP_CTRL = 5'h00;
    localparam logic [4:0] TOP_REV  = 5'h10;

    typedef enum logic [2:0] {
        SEL_EN,
        SEL_RELOAD,
        SEL_COUNT,
        SEL_WRAPS,
        SEL_STAT,
        SEL_CLR,
        SEL_MASK,
        SEL_NONE
    } reg_sel_e;

    // per-channel write / read strobes
    typedef struct packed {
        logic wr_en;
        logic wr_reload;
        logic wr_clr;
        logic wr_mask;
        logic rd_wraps;
    } chan_strb_t;

    // readable state of one channel
    typedef struct packed {
        logic          en;
        logic [DW-1:0] reload;
        logic [DW-1:0] snap;
        logic [DW-1:0] wraps;
        logic          st;
        logic          mask;
    } chan_view_t;

    function automatic reg_sel_e decode_off(input logic [4:0] off);
        case (off)
            5'h00:   return SEL_EN;
            5'h04:   return SEL_RELOAD;
            5'h08:   return SEL_COUNT;
            5'h0C:   return SEL_WRAPS;
            5'h10:   return SEL_STAT;
            5'h14:   return SEL_CLR;
            5'h18:   return SEL_MASK;
            default: return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/dtmr_decode.sv
module dtmr_decode
    import dtmr_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 8
) (
    input  logic                   [AW-1:0]  addr,
    input  logic                             wr_en,
    input  logic                             rd_en,
    output chan_strb_t             [NCH-1:0] strb,
    output logic                   [NCH-1:0] hit_ch,
    output reg_sel_e                         sel,
    output logic                             top_ctrl,
    output logic                             top_rev,
    output logic                             wr_ctrl
);
    localparam int PW = AW - 5;

    logic [PW-1:0] page;
    logic          aligned;

    assign page     = addr[AW-1:5];
    assign aligned  = (addr[1:0] == 2'b00);
    assign sel      = aligned ? decode_off(addr[4:0]) : SEL_NONE;
    assign top_ctrl = (page == '0) && (addr[4:0] == TOP_CTRL);
    assign top_rev  = (page == '0) && (addr[4:0] == TOP_REV);
    assign wr_ctrl  = wr_en && top_ctrl;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign hit_ch[i]         = (page == PW'(i + 1));
        assign strb[i].wr_en     = wr_en && hit_ch[i] && (sel == SEL_EN);
        assign strb[i].wr_reload = wr_en && hit_ch[i] && (sel == SEL_RELOAD);
        assign strb[i].wr_clr    = wr_en && hit_ch[i] && (sel == SEL_CLR);
        assign strb[i].wr_mask   = wr_en && hit_ch[i] && (sel == SEL_MASK);
        assign strb[i].rd_wraps  = rd_en && hit_ch[i] && (sel == SEL_WRAPS);
    end

endmodule

// File: rtl/dtmr_channel.sv
module dtmr_channel
    import dtmr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          gen,
    input  chan_strb_t    strb,
    input  logic [DW-1:0] wdata,
    output chan_view_t    view,
    output logic [DW-1:0] count,
    output logic          run,
    output logic          load,
    output logic          wrap,
    output logic          clr,
    output logic          irq
);
    logic          en_q, st_q, mask_q;
    logic [DW-1:0] reload_q, cnt_q, wraps_q, snap_q;

    assign run  = gen && en_q;
    assign load = strb.wr_en && wdata[0] && !en_q;
    assign wrap = run && (cnt_q == '0);
    assign clr  = strb.wr_clr && wdata[0];
    assign irq  = st_q && mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= 1'b0;
            st_q     <= 1'b0;
            mask_q   <= 1'b0;
            reload_q <= '0;
            cnt_q    <= '0;
            wraps_q  <= '0;
            snap_q   <= '0;
        end else begin
            if (strb.wr_en)     en_q     <= wdata[0];
            if (strb.wr_reload) reload_q <= wdata;
            if (strb.wr_mask)   mask_q   <= wdata[0];

            if (load)           cnt_q <= reload_q;
            else if (wrap)      cnt_q <= reload_q;
            else if (run)       cnt_q <= cnt_q - 1'b1;

            if (wrap)           wraps_q <= wraps_q + 1'b1;

            if (wrap)           st_q <= 1'b1;
            else if (clr)       st_q <= 1'b0;

            if (strb.rd_wraps)  snap_q <= cnt_q;
        end
    end

    assign count       = cnt_q;
    assign view.en     = en_q;
    assign view.reload = reload_q;
    assign view.snap   = snap_q;
    assign view.wraps  = wraps_q;
    assign view.st     = st_q;
    assign view.mask   = mask_q;

endmodule

// File: rtl/quad_down_timer.sv
module quad_down_timer
    import dtmr_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  wdata,
    input  logic           wr_en,
    input  logic           rd_en,
    output logic [DW-1:0]  rdata,
    output logic [NCH-1:0] irq,
    output logic           irq_any
);
    chan_strb_t [NCH-1:0] strb;
    chan_view_t [NCH-1:0] view;
    logic       [NCH-1:0] hit_ch;
    reg_sel_e             sel;
    logic                 top_ctrl, top_rev, wr_ctrl;
    logic                 gen;
    logic [DW-1:0]        rd_next;

    logic [NCH-1:0][DW-1:0] cnt_a, reload_a, wraps_a, snap_a;
    logic [NCH-1:0]         run_a, load_a, wrap_a, clr_a, st_a, mask_a, rdw_a;

    dtmr_decode #(.NCH(NCH), .AW(AW)) u_dec (
        .addr     (addr),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .strb     (strb),
        .hit_ch   (hit_ch),
        .sel      (sel),
        .top_ctrl (top_ctrl),
        .top_rev  (top_rev),
        .wr_ctrl  (wr_ctrl)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        dtmr_channel u_ch (
            .clk   (clk),
            .rst   (rst),
            .gen   (gen),
            .strb  (strb[i]),
            .wdata (wdata),
            .view  (view[i]),
            .count (cnt_a[i]),
            .run   (run_a[i]),
            .load  (load_a[i]),
            .wrap  (wrap_a[i]),
            .clr   (clr_a[i]),
            .irq   (irq[i])
        );
        assign reload_a[i] = view[i].reload;
        assign wraps_a[i]  = view[i].wraps;
        assign snap_a[i]   = view[i].snap;
        assign st_a[i]     = view[i].st;
        assign mask_a[i]   = view[i].mask;
        assign rdw_a[i]    = strb[i].rd_wraps;
    end

    assign irq_any = |irq;

    always_ff @(posedge clk) begin
        if (rst)          gen <= 1'b0;
        else if (wr_ctrl) gen <= wdata[0];
    end

    always_comb begin
        rd_next = '0;
        if (top_ctrl) rd_next = {{(DW-1){1'b0}}, gen};
        if (top_rev)  rd_next = REVISION;
        for (int i = 0; i < NCH; i++) begin
            if (hit_ch[i]) begin
                case (sel)
                    SEL_EN:     rd_next = {{(DW-1){1'b0}}, view[i].en};
                    SEL_RELOAD: rd_next = view[i].reload;
                    SEL_COUNT:  rd_next = view[i].snap;
                    SEL_WRAPS:  rd_next = view[i].wraps;
                    SEL_STAT:   rd_next = {{(DW-1){1'b0}}, view[i].st};
                    SEL_MASK:   rd_next = {{(DW-1){1'b0}}, view[i].mask};
                    default:    rd_next = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= rd_next;
    end

endmodule

// File: rtl/dtmr_checker.sv
module dtmr_checker #(
    parameter int NCH = 4
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    gen,
    input logic [NCH-1:0][31:0]    cnt_a,
    input logic [NCH-1:0][31:0]    reload_a,
    input logic [NCH-1:0][31:0]    wraps_a,
    input logic [NCH-1:0][31:0]    snap_a,
    input logic [NCH-1:0]          run_a,
    input logic [NCH-1:0]          load_a,
    input logic [NCH-1:0]          clr_a,
    input logic [NCH-1:0]          st_a,
    input logic [NCH-1:0]          mask_a,
    input logic [NCH-1:0]          rdw_a,
    input logic [NCH-1:0]          irq,
    input logic                    irq_any
);
    for (genvar i = 0; i < NCH; i++) begin : g_chk
        a_r3_gate_hold: assert property (@(posedge clk) disable iff (rst)
            (!gen && !load_a[i]) |=> $stable(cnt_a[i]));

        a_r5_load: assert property (@(posedge clk) disable iff (rst)
            load_a[i] |=> (cnt_a[i] == $past(reload_a[i])));

        a_r6_decrement: assert property (@(posedge clk) disable iff (rst)
            (run_a[i] && cnt_a[i] != 32'd0) |=> (cnt_a[i] == $past(cnt_a[i]) - 32'd1));

        a_r7_wrap: assert property (@(posedge clk) disable iff (rst)
            (run_a[i] && cnt_a[i] == 32'd0) |=>
                (cnt_a[i] == $past(reload_a[i]) && wraps_a[i] == $past(wraps_a[i]) + 32'd1 && st_a[i]));

        a_r8_snapshot: assert property (@(posedge clk) disable iff (rst)
            rdw_a[i] |=> (snap_a[i] == $past(cnt_a[i])));

        a_r10_clear: assert property (@(posedge clk) disable iff (rst)
            (clr_a[i] && !(run_a[i] && cnt_a[i] == 32'd0)) |=> !st_a[i]);

        a_r11_masked_low: assert property (@(posedge clk) disable iff (rst)
            !mask_a[i] |-> !irq[i]);
    end

    a_r11_any_masked: assert property (@(posedge clk) disable iff (rst)
        (mask_a == '0) |-> !irq_any);

endmodule

bind quad_down_timer dtmr_checker #(.NCH(NCH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .gen      (gen),
    .cnt_a    (cnt_a),
    .reload_a (reload_a),
    .wraps_a  (wraps_a),
    .snap_a   (snap_a),
    .run_a    (run_a),
    .load_a   (load_a),
    .clr_a    (clr_a),
    .st_a     (st_a),
    .mask_a   (mask_a),
    .rdw_a    (rdw_a),
    .irq      (irq),
    .irq_any  (irq_any)
);

// File: tb/tb_quad_down_timer.sv
module tb_quad_down_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] rdata;
    logic [3:0]  irq;
    logic        irq_any;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int last_edge = 0;
    bit done = 0;

    quad_down_timer dut (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata),
        .irq(irq), .irq_any(irq_any)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] ca(input int ch, input int off);
        return 8'(32 * (ch + 1) + off);
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        last_edge = cyc;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
        last_edge = cyc;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 rdata after reset", rdata, 32'h0);
        check("R1 irq after reset", {27'h0, irq_any, irq}, 32'h0);
        bus_rd(8'h00, d); check("R1 ctrl reset", d, 32'h0);
        bus_rd(8'h10, d); check("R1 ident", d, 32'h0002_0001);
        bus_rd(ca(0, 8'h00), d); check("R1 ch0 enable reset", d, 32'h0);
        bus_rd(ca(3, 8'h0C), d); check("R1 ch3 wraps reset", d, 32'h0);
        bus_rd(ca(3, 8'h08), d); check("R1 ch3 count reset", d, 32'h0);
    endtask

    // global enable off: load on local enable, no counting
    task automatic t_gate();
        logic [31:0] d;
        bus_wr(ca(0, 8'h04), 32'd5);
        bus_rd(ca(0, 8'h04), d); check("R2 reload readback", d, 32'd5);
        bus_wr(ca(0, 8'h00), 32'd1);
        idle(8);
        bus_rd(ca(0, 8'h0C), d); check("R3 no wraps while global off", d, 32'd0);
        bus_rd(ca(0, 8'h08), d); check("R5 load while global off", d, 32'd5);
    endtask

    int g_edge;
    logic [31:0] snap_first;

    task automatic t_count();
        logic [31:0] d;
        int k;
        bus_wr(8'h00, 32'd1);
        g_edge = last_edge;
        idle(20);
        bus_rd(ca(0, 8'h0C), d);
        k = last_edge - g_edge;
        check("R7 wrap count", d, 32'((k - 1) / 6));
        bus_rd(ca(0, 8'h08), d);
        snap_first = d;
        check("R6 captured count", d, 32'(5 - ((k - 1) % 6)));
        idle(3);
        check("R9 rdata holds", rdata, snap_first);
        idle(4);
        bus_rd(ca(0, 8'h08), d); check("R8 count not refreshed", d, snap_first);
        bus_rd(ca(0, 8'h10), d); check("R7 status set", d, 32'd1);
        check("R11 masked irq low", {31'h0, irq[0]}, 32'd0);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        bus_wr(ca(0, 8'h18), 32'd1);
        check("R11 irq with mask", {31'h0, irq[0]}, 32'd1);
        check("R11 irq_any", {31'h0, irq_any}, 32'd1);
        bus_wr(ca(0, 8'h00), 32'd0);
        bus_wr(ca(0, 8'h14), 32'h2);
        bus_rd(ca(0, 8'h10), d); check("R10 bit0 zero keeps status", d, 32'd1);
        bus_wr(ca(0, 8'h14), 32'h1);
        check("R10 irq after clear", {27'h0, irq_any, irq}, 32'h0);
        bus_rd(ca(0, 8'h10), d); check("R10 status cleared", d, 32'd0);
        bus_rd(ca(0, 8'h14), d); check("R10 clear reads zero", d, 32'd0);
    endtask

    task automatic t_stop();
        logic [31:0] d, c1, w1;
        bus_rd(ca(0, 8'h0C), w1);
        bus_rd(ca(0, 8'h08), c1);
        idle(5);
        bus_rd(ca(0, 8'h0C), d); check("R4 wraps frozen", d, w1);
        bus_rd(ca(0, 8'h08), d); check("R4 count frozen", d, c1);
    endtask

    task automatic t_free();
        logic [31:0] d, v1;
        int e, k;
        bus_wr(ca(1, 8'h04), 32'hFFFF_FFFF);
        bus_wr(ca(1, 8'h00), 32'd1);
        e = last_edge;
        idle(3);
        bus_rd(ca(1, 8'h0C), d);
        k = last_edge - e;
        bus_rd(ca(1, 8'h08), v1);
        check("R12 inverse first", ~v1, 32'(k - 1));
        idle(10);
        bus_rd(ca(1, 8'h0C), d);
        k = last_edge - e;
        check("R12 no wrap", d, 32'd0);
        bus_rd(ca(1, 8'h08), d);
        check("R12 inverse second", ~d, 32'(k - 1));
        check("R12 inverse rises", {31'h0, (~d > ~v1)}, 32'd1);
    endtask

    task automatic t_map();
        logic [31:0] d;
        bus_wr(ca(3, 8'h04), 32'hA5A5_0003);
        bus_rd(ca(3, 8'h04), d); check("R2 ch3 reload", d, 32'hA5A5_0003);
        bus_rd(ca(2, 8'h04), d); check("R2 ch2 untouched", d, 32'h0);
        bus_wr(ca(3, 8'h18), 32'd1);
        bus_rd(ca(3, 8'h18), d); check("R2 ch3 mask", d, 32'd1);
        bus_rd(ca(1, 8'h00), d); check("R2 ch1 enable", d, 32'd1);
        bus_wr(8'h10, 32'h1234_5678);
        bus_rd(8'h10, d); check("R2 ident not writable", d, 32'h0002_0001);
        bus_rd(8'h0C, d); check("R2 unmapped", d, 32'h0);
        bus_rd(8'hA0, d); check("R2 beyond channels", d, 32'h0);
        bus_rd(8'h25, d); check("R2 misaligned", d, 32'h0);
    endtask

    task automatic t_global_off();
        logic [31:0] d, c1;
        bus_wr(8'h00, 32'd0);
        bus_rd(ca(1, 8'h0C), d);
        bus_rd(ca(1, 8'h08), c1);
        idle(6);
        bus_rd(ca(1, 8'h0C), d);
        bus_rd(ca(1, 8'h08), d); check("R3 global off holds", d, c1);
        bus_rd(8'h00, d); check("R3 ctrl readback", d, 32'd0);
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        t_reset();
        t_gate();
        t_count();
        t_irq();
        t_stop();
        t_free();
        t_map();
        t_global_off();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule